// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block watches the protection flags around a full-bridge motor driver. It decides, cycle by cycle, when the bridge must be forced off and when the active-low fault flag must be pulled. Its inputs are single-bit flags: an overcurrent flag from the output switches, a current-sense comparator for the latched current-limit option, thermal warning and thermal shutdown flags, and supply and charge-pump undervoltage flags. Two more inputs carry the PWM drive-transition pulse and the standby request. It has no data path. Every pin is a plain control or status level, so no valid/ready handshake and no back-pressure apply.

A short or a current-limit trip latches the bridge off and pulls the fault flag. The block then releases both by itself once a retry timer runs out. Sensing is blind for a short window after each drive transition, so that switching spikes do not trip the bridge. The current-limit latch path works only when the limit-select input is low. A thermal warning raises the fault flag but leaves the bridge running. A thermal shutdown stops the bridge but does not raise the flag. Undervoltage does both. Standby clears all timers and latches, holds the bridge off and releases the flag. After standby, the bridge stays off for a power-up delay. All timings are parameters counted in clock cycles. Both outputs are driven from flops, so each reacts one clock after the edge that samples its cause.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While reset is applied, and right after it, `bridge_off` is 1 and `fault_n` is 1.
- R2: When `oc_flag` is 1 on a clock edge outside standby and outside the blanking window, `bridge_off` is 1 and `fault_n` is 0 from that edge on.
- R3: After the last edge that samples a qualified trip, the latch holds `bridge_off` at 1 and `fault_n` at 0 for exactly RETRY_CYCLES cycles and then releases them. A new qualified trip during that time restarts the full count.
- R4: A trip flag sampled on the same edge as `drive_edge`=1, or on any of the next BLANK_CYCLES edges, is ignored.
- R5: When `limit_sel`=0, `sense_trip`=1 acts exactly like an overcurrent trip: the same latch, the same blanking and the same retry count.
- R6: When `limit_sel`=1, `sense_trip` has no effect on either output.
- R7: `thermal_sd`=1 sets `bridge_off` one cycle later and keeps it set while the flag stays high. It does not change `fault_n`.
- R8: `thermal_warn`=1 outside standby pulls `fault_n` to 0 one cycle later. It does not change `bridge_off`.
- R9: `vbb_uv`=1 or `vcp_uv`=1 outside standby gives `bridge_off`=1 and `fault_n`=0 one cycle later, for as long as the flag stays high.
- R10: `standby`=1 gives `bridge_off`=1 and `fault_n`=1 one cycle later. It also clears the trip latch, the retry count and the blanking window.
- R11: After reset or standby, `bridge_off` stays 1 until PWRUP_CYCLES edges have sampled `standby`=0. It is released right after the last of those edges, unless some other cause holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Low-power standby request, active high |
| drive_edge | input | 1 | One-cycle pulse on each bridge drive transition |
| oc_flag | input | 1 | Output short / overcurrent flag |
| sense_trip | input | 1 | Sense voltage above the latch-off threshold |
| limit_sel | input | 1 | 0: current-limit latch-off enabled; 1: disabled |
| thermal_warn | input | 1 | Die temperature warning |
| thermal_sd | input | 1 | Die temperature shutdown (hysteresis applied upstream) |
| vbb_uv | input | 1 | Load supply undervoltage |
| vcp_uv | input | 1 | Charge-pump undervoltage |
| bridge_off | output | 1 | 1 forces all bridge outputs off |
| fault_n | output | 1 | Fault flag, active low |

## Verification
Most internal errors in this block appear at the ports within one retry period. A retry counter that is off by one moves the release of `bridge_off` and `fault_n` by a cycle. A counter that misses its restart releases the bridge too early after a second trip. A wrong blanking count shows up within BLANK_CYCLES+1 edges of a `drive_edge` pulse, as a latch that should not happen or one that is missing. Errors in the standby clearing or the power-up count show up on the first release after standby. The reference model compares both outputs on every clock, so the first wrong cycle is flagged.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bfs_blank_timer.sv
module bfs_blank_timer #(
  parameter int unsigned BLANK_CYCLES = 680
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic drive_edge,
  output logic blank_ok
);
  generate
    if (BLANK_CYCLES == 0) begin : g_none
      assign blank_ok = !drive_edge;
    end else begin : g_cnt
      localparam int unsigned W = bfs_pkg::cnt_w(BLANK_CYCLES);
      localparam logic [W-1:0] LOAD = W'(BLANK_CYCLES);
      logic [W-1:0] left;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               left <= '0;
        else if (clear)           left <= '0;
        else if (drive_edge)      left <= LOAD;
        else if (left != '0)      left <= left - 1'b1;
      end

      assign blank_ok = (left == '0) && !drive_edge;
    end
  endgenerate
endmodule

// File: rtl/bfs_retry_latch.sv
module bfs_retry_latch #(
  parameter int unsigned RETRY_CYCLES = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic trip,
  output logic latched
);
  localparam int unsigned W = bfs_pkg::cnt_w(RETRY_CYCLES);
  localparam logic [W-1:0] LAST = W'(RETRY_CYCLES - 1);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      held    <= '0;
    end else if (clear) begin
      latched <= 1'b0;
      held    <= '0;
    end else if (trip) begin
      latched <= 1'b1;
      held    <= '0;
    end else if (latched) begin
      if (held == LAST) begin
        latched <= 1'b0;
        held    <= '0;
      end else begin
        held <= held + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfs_powerup_hold.sv
module bfs_powerup_hold #(
  parameter int unsigned PWRUP_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  output logic hold
);
  generate
    if (PWRUP_CYCLES == 0) begin : g_none
      assign hold = 1'b0;
    end else begin : g_cnt
      localparam int unsigned W = bfs_pkg::cnt_w(PWRUP_CYCLES);
      localparam logic [W-1:0] LOAD = W'(PWRUP_CYCLES);
      logic [W-1:0] left;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left <= LOAD;
        else if (standby)    left <= LOAD;
        else if (left != '0) left <= left - 1'b1;
      end

      assign hold = (left != '0);
    end
  endgenerate
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
  parameter int unsigned BLANK_CYCLES = 680,
  parameter int unsigned RETRY_CYCLES = 240000,
  parameter int unsigned PWRUP_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic drive_edge,
  input  logic oc_flag,
  input  logic sense_trip,
  input  logic limit_sel,
  input  logic thermal_warn,
  input  logic thermal_sd,
  input  logic vbb_uv,
  input  logic vcp_uv,
  output logic bridge_off,
  output logic fault_n
);
  logic blank_ok;
  logic trip;
  logic latched;
  logic pwr_hold;
  logic stby_q, warn_q, tsd_q, uv_q;

  bfs_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (standby),
    .drive_edge (drive_edge),
    .blank_ok   (blank_ok)
  );

  // Latch-off sources: switch overcurrent always, sense trip only in latch mode.
  assign trip = !standby && blank_ok && (oc_flag || (sense_trip && !limit_sel));

  bfs_retry_latch #(.RETRY_CYCLES(RETRY_CYCLES)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (standby),
    .trip    (trip),
    .latched (latched)
  );

  bfs_powerup_hold #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (standby),
    .hold    (pwr_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      warn_q <= 1'b0;
      tsd_q  <= 1'b0;
      uv_q   <= 1'b0;
    end else begin
      stby_q <= standby;
      warn_q <= thermal_warn;
      tsd_q  <= thermal_sd;
      uv_q   <= vbb_uv | vcp_uv;
    end
  end

  assign bridge_off = stby_q | latched | tsd_q | uv_q | pwr_hold;
  assign fault_n    = stby_q | ~(latched | warn_q | uv_q);
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int unsigned PWRUP_CYCLES = 80000
) (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic oc_flag,
  input logic sense_trip,
  input logic limit_sel,
  input logic thermal_warn,
  input logic thermal_sd,
  input logic vbb_uv,
  input logic vcp_uv,
  input logic blank_ok,
  input logic bridge_off,
  input logic fault_n
);
  localparam bit LONG_HOLD = (PWRUP_CYCLES > 1);

  AST_OC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && blank_ok && oc_flag) |=> (bridge_off && !fault_n)); // R2

  AST_SENSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && blank_ok && sense_trip && !limit_sel) |=> (bridge_off && !fault_n)); // R5

  AST_TSD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_sd |=> bridge_off); // R7

  AST_WARN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal_warn && !standby) |=> !fault_n); // R8

  AST_UV_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((vbb_uv || vcp_uv) && !standby) |=> (bridge_off && !fault_n)); // R9

  AST_STBY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (bridge_off && fault_n)); // R10

  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (LONG_HOLD && $fell(standby)) |=> bridge_off); // R11
endmodule

bind bridge_fault_supervisor bfs_checker #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby      (standby),
  .oc_flag      (oc_flag),
  .sense_trip   (sense_trip),
  .limit_sel    (limit_sel),
  .thermal_warn (thermal_warn),
  .thermal_sd   (thermal_sd),
  .vbb_uv       (vbb_uv),
  .vcp_uv       (vcp_uv),
  .blank_ok     (blank_ok),
  .bridge_off   (bridge_off),
  .fault_n      (fault_n)
);

// File: tb/tb_bridge_fault_supervisor.sv
`timescale 1ns/1ps
module tb_bridge_fault_supervisor;
  localparam int B = 3;
  localparam int R = 12;
  localparam int P = 5;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0, drive_edge = 1'b0, oc_flag = 1'b0, sense_trip = 1'b0;
  logic limit_sel = 1'b1, thermal_warn = 1'b0, thermal_sd = 1'b0;
  logic vbb_uv = 1'b0, vcp_uv = 1'b0;
  logic bridge_off, fault_n;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_blank = 0;
  int m_latch = 0;
  int m_pwr = P;
  bit m_stby = 0, m_warn = 0, m_tsd = 0, m_uv = 0;

  always #2.5 clk = ~clk;

  bridge_fault_supervisor #(.BLANK_CYCLES(B), .RETRY_CYCLES(R), .PWRUP_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .drive_edge(drive_edge),
    .oc_flag(oc_flag), .sense_trip(sense_trip), .limit_sel(limit_sel),
    .thermal_warn(thermal_warn), .thermal_sd(thermal_sd),
    .vbb_uv(vbb_uv), .vcp_uv(vcp_uv),
    .bridge_off(bridge_off), .fault_n(fault_n)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_blank = 0; m_latch = 0; m_pwr = P;
      m_stby = 0; m_warn = 0; m_tsd = 0; m_uv = 0;
    end else begin
      if (standby) begin
        m_blank = 0; m_latch = 0; m_pwr = P;
      end else begin
        bit ign;
        bit trip;
        ign = drive_edge || (m_blank > 0);
        m_blank = drive_edge ? B : ((m_blank > 0) ? m_blank - 1 : 0);
        trip = !ign && (oc_flag || (sense_trip && !limit_sel));
        m_latch = trip ? R : ((m_latch > 0) ? m_latch - 1 : 0);
        m_pwr = (m_pwr > 0) ? m_pwr - 1 : 0;
      end
      m_stby = standby; m_warn = thermal_warn; m_tsd = thermal_sd;
      m_uv = vbb_uv || vcp_uv;
    end
  end

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      logic e_off, e_fn;
      e_off = m_stby || (m_latch > 0) || m_tsd || m_uv || (m_pwr > 0);
      e_fn  = m_stby || !((m_latch > 0) || m_warn || m_uv);
      check_bit(cur_req, "bridge_off", bridge_off, e_off);
      check_bit(cur_req, "fault_n", fault_n, e_fn);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // count cycles bridge_off stays high, sampled at negedges
  task automatic count_off(output int n);
    n = 0;
    while (bridge_off === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    step(3);
    cur_req = "R1";
    check_bit("R1", "bridge_off in reset", bridge_off, 1'b1);
    check_bit("R1", "fault_n in reset", fault_n, 1'b1);
    rst_n = 1'b1;

    // R11: power-up hold after reset
    cur_req = "R11";
    step(P - 1);
    check_bit("R11", "held before last count", bridge_off, 1'b1);
    step(1);
    check_bit("R11", "released after count", bridge_off, 1'b0);
    step(2);

    // R2 / R3: single overcurrent pulse
    cur_req = "R2";
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    check_bit("R2", "bridge_off after oc", bridge_off, 1'b1);
    check_bit("R2", "fault_n after oc", fault_n, 1'b0);
    cur_req = "R3";
    count_off(n);
    check_int("R3", "retry length", n, R);
    check_bit("R3", "fault released", fault_n, 1'b1);
    step(2);

    // R3: retrigger restarts the retry count
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    step(R / 2);
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    count_off(n);
    check_int("R3", "retry after restart", n, R);
    step(2);

    // R4: blanking window after a drive transition
    cur_req = "R4";
    drive_edge = 1'b1; oc_flag = 1'b1; step(1); drive_edge = 1'b0;
    step(B);
    oc_flag = 1'b0;
    check_bit("R4", "no latch inside blanking", bridge_off, 1'b0);
    check_bit("R4", "no fault inside blanking", fault_n, 1'b1);
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    check_bit("R4", "latch after blanking", bridge_off, 1'b1);
    step(R + 2);

    // R5: sense trip in latch mode
    cur_req = "R5";
    limit_sel = 1'b0;
    sense_trip = 1'b1; step(1); sense_trip = 1'b0;
    check_bit("R5", "sense latch", fault_n, 1'b0);
    count_off(n);
    check_int("R5", "sense retry length", n, R);
    drive_edge = 1'b1; step(1); drive_edge = 1'b0;
    sense_trip = 1'b1; step(2); sense_trip = 1'b0;
    check_bit("R5", "sense blanked", bridge_off, 1'b0);
    step(B + 2);

    // R6: sense trip ignored in regulate mode
    cur_req = "R6";
    limit_sel = 1'b1;
    sense_trip = 1'b1; step(6); sense_trip = 1'b0;
    check_bit("R6", "bridge_off unaffected", bridge_off, 1'b0);
    check_bit("R6", "fault_n unaffected", fault_n, 1'b1);
    step(2);

    // R7: thermal shutdown
    cur_req = "R7";
    thermal_sd = 1'b1; step(1);
    check_bit("R7", "tsd off", bridge_off, 1'b1);
    check_bit("R7", "tsd no flag", fault_n, 1'b1);
    step(4); thermal_sd = 1'b0; step(1);
    check_bit("R7", "tsd release", bridge_off, 1'b0);

    // R8: thermal warning
    cur_req = "R8";
    thermal_warn = 1'b1; step(1);
    check_bit("R8", "warn flag", fault_n, 1'b0);
    check_bit("R8", "warn keeps running", bridge_off, 1'b0);
    step(3); thermal_warn = 1'b0; step(1);
    check_bit("R8", "warn release", fault_n, 1'b1);

    // R9: undervoltage on either rail
    cur_req = "R9";
    vbb_uv = 1'b1; step(1);
    check_bit("R9", "vbb uv off", bridge_off, 1'b1);
    check_bit("R9", "vbb uv flag", fault_n, 1'b0);
    vbb_uv = 1'b0; vcp_uv = 1'b1; step(3);
    check_bit("R9", "vcp uv flag", fault_n, 1'b0);
    vcp_uv = 1'b0; step(1);
    check_bit("R9", "uv release", bridge_off, 1'b0);

    // R10: standby clears a latched trip and releases the flag
    cur_req = "R10";
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    thermal_warn = 1'b1;
    standby = 1'b1; step(1);
    check_bit("R10", "standby flag released", fault_n, 1'b1);
    check_bit("R10", "standby off", bridge_off, 1'b1);
    oc_flag = 1'b1; step(2); oc_flag = 1'b0;
    thermal_warn = 1'b0;
    standby = 1'b0;
    cur_req = "R11";
    step(P);
    check_bit("R10", "latch cleared by standby", bridge_off, 1'b0);
    check_bit("R11", "released after standby", fault_n, 1'b1);

    // standby in the middle of a blanking window
    drive_edge = 1'b1; step(1); drive_edge = 1'b0;
    standby = 1'b1; step(1); standby = 1'b0;
    step(P);
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    check_bit("R10", "blanking cleared by standby", bridge_off, 1'b1);
    step(R + 3);

    finish_run();
  end

  initial begin
    #(MAX_CYCLES * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule